// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is a 16-pin parallel I/O port with a simple register bus. Each pin has five configuration bits: direction, output latch, open-drain, weak-pullup request and digital-enable for pins that share an analog input. From these bits the block drives a per-pin output value, an output enable and a pullup request to pad logic outside the block. It also takes the raw pad levels back in through a two-flop synchronizer.

Two bus addresses both write the output latch. They differ on read: the latch address returns the stored latch, and the pin address returns the synchronized level on the pad. As a result, a read-modify-write done through the pin address stores whatever the pads show, not what was last written.

Parameters select which pins exist, which pins can request a pullup and which pins share an analog input. Bits for pins that do not exist read as zero and ignore writes.

Top module: `gpio_port16`

Register addresses (`bus_addr`): 0 direction, 1 pin level, 2 output latch, 3 open-drain, 4 pullup enable, 5 digital enable. Addresses 6 and 7 read as zero and ignore writes. Bit i of every register belongs to pin i.

## Requirements
- R1: After reset, the direction register reads all ones on implemented pins. The latch, open-drain, pullup and digital-enable registers read zero, and no output enable is asserted.
- R2: A direction bit of 0 makes the pin an output, so its output enable is asserted. A direction bit of 1 makes the pin an input and deasserts its output enable.
- R3: A write to address 1 and a write to address 2 both load the output latch. A following read of address 2 returns the written value masked to implemented pins.
- R4: A read of address 1 returns the pad levels through a two-flop synchronizer. A pad change made just after clock edge E is not visible at the read after edge E+1, and it is visible at the read after edge E+2.
- R5: With the open-drain bit at 1, the pad output value is 0. The output enable is asserted only while the latch bit is 0, and otherwise the pin is released.
- R6: An open-drain output with latch 1 that is held low externally reads 0 at address 1 and 1 at address 2.
- R7: The pullup request follows pullup-enable bit 1 only on pins that support a pullup. On pins without pullup support, the bit reads 0 and never raises the request.
- R8: On a pin that shares an analog input, a digital-enable bit of 0 forces its pin read to 0 and deasserts its output enable. On pins without an analog input, the digital-enable bit reads 0 and has no effect.
- R9: Unimplemented pins read 0 in every register and in the pin read. They never assert an output enable, and writes to them are ignored.
- R10: A write to address 1 stores exactly the written word. Reading address 1, setting a bit and writing the result back therefore clears any latch bit whose pad was held low.
- R11: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pad_in | input | 16 | Raw pad levels |
| pad_out | output | 16 | Value to drive on each pad |
| pad_oe | output | 16 | Per-pad driver enable |
| pad_pu | output | 16 | Per-pad weak-pullup request |

## Verification
The bench models the pads and can force pins low, which creates the case where the latch and the pad disagree. A design that returned the latch at the pin address, or the reverse, fails the held-low and read-modify-write checks. The pin read is sampled one and two edges after a pad change, so a synchronizer with one flop too few or one too many is caught. The remaining checks target masking. If analog-capable pins are not gated, pin reads show stray ones. If pullups are not masked, a request appears on an unsupported pin. If unimplemented bits are not masked, they show up in register reads and output enables.

// File: rtl/gpio_pkg.sv
// Shared register-select encoding for the I/O port.
package gpio_pkg;
    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_PIN  = 3'd1,
        SEL_LAT  = 3'd2,
        SEL_OD   = 3'd3,
        SEL_PU   = 3'd4,
        SEL_DIG  = 3'd5,
        SEL_RSV6 = 3'd6,
        SEL_RSV7 = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Per-pin configuration registers of the port.
// Assumes: the bus writes one register per cycle. Bits outside the
// implemented, pullup-capable or analog-capable masks are held at zero.
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int          WIDTH     = 16,
    parameter logic [15:0] IMPL_MASK = 16'h3FFF,
    parameter logic [15:0] PULL_MASK = 16'h00FF,
    parameter logic [15:0] ANA_MASK  = 16'h0F00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       wr_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] od_q,
    output logic [WIDTH-1:0] pu_q,
    output logic [WIDTH-1:0] dig_q
);
    localparam logic [WIDTH-1:0] IMPL = IMPL_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] PUOK = PULL_MASK[WIDTH-1:0] & IMPL;
    localparam logic [WIDTH-1:0] ANOK = ANA_MASK[WIDTH-1:0] & IMPL;

    // Register update: reset to inputs, analog mode, everything else cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= IMPL;
            lat_q <= '0;
            od_q  <= '0;
            pu_q  <= '0;
            dig_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_DIR:          dir_q <= wr_data & IMPL;
                SEL_PIN, SEL_LAT: lat_q <= wr_data & IMPL;
                SEL_OD:           od_q  <= wr_data & IMPL;
                SEL_PU:           pu_q  <= wr_data & PUOK;
                SEL_DIG:          dig_q <= wr_data & ANOK;
                default:          ;
            endcase
        end
    end

    // R3
    pin_write_loads_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel_e'(wr_sel) == SEL_PIN) |=> (lat_q == ($past(wr_data) & IMPL)));

    // R11
    reserved_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel[2:1] == 2'b11) |=> ($stable(dir_q) && $stable(lat_q) && $stable(dig_q)));
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for the raw pad levels.
// Assumes: the pads are asynchronous to clk. The flops carry no reset,
// and their contents are valid two cycles after the clock starts.
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage1;

    // Two register stages, one per bit, made by a generate loop.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            stage1[i]   <= pin_i[i];
            pin_sync[i] <= stage1[i];
        end
    end

    // R4
    sync_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sync == $past(pin_i, 2));
endmodule

// File: rtl/gpio_pad_ctl.sv
// Pad drive logic. From the configuration of each pin it derives the value
// to drive, the driver enable and the pullup request.
// Assumes: the configuration inputs are already masked to implemented pins.
module gpio_pad_ctl #(
    parameter int          WIDTH     = 16,
    parameter logic [15:0] IMPL_MASK = 16'h3FFF
) (
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] lat_i,
    input  logic [WIDTH-1:0] od_i,
    input  logic [WIDTH-1:0] pu_i,
    input  logic [WIDTH-1:0] dig_eff_i,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    localparam logic [WIDTH-1:0] IMPL = IMPL_MASK[WIDTH-1:0];

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Per-pin drive decision. Open-drain suppresses the high side.
        always_comb begin
            pad_out[i] = IMPL[i] & lat_i[i] & ~od_i[i];
            pad_oe[i]  = IMPL[i] & ~dir_i[i] & dig_eff_i[i] & ~(od_i[i] & lat_i[i]);
            pad_pu[i]  = IMPL[i] & pu_i[i];
        end
    end
endmodule

// File: rtl/gpio_port16.sv
// Top of the 16-pin I/O port: configuration registers, pad drive logic,
// pad synchronizer and read multiplexer.
// Assumes: bus_rdata is sampled by the bus master in the same cycle that
// bus_addr is presented. Reads have no side effects.
module gpio_port16
    import gpio_pkg::*;
#(
    parameter int          WIDTH     = 16,
    parameter logic [15:0] IMPL_MASK = 16'h3FFF,
    parameter logic [15:0] PULL_MASK = 16'h00FF,
    parameter logic [15:0] ANA_MASK  = 16'h0F00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wen,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    localparam logic [WIDTH-1:0] IMPL = IMPL_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ANOK = ANA_MASK[WIDTH-1:0] & IMPL;

    logic [WIDTH-1:0] dir_q, lat_q, od_q, pu_q, dig_q;
    logic [WIDTH-1:0] dig_eff, pin_sync, pin_view;

    gpio_cfg_regs #(
        .WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK),
        .PULL_MASK(PULL_MASK), .ANA_MASK(ANA_MASK)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_sel(bus_addr), .wr_en(bus_wen),
        .wr_data(bus_wdata), .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q),
        .pu_q(pu_q), .dig_q(dig_q)
    );

    // Pins without an analog function are always digital.
    always_comb dig_eff = dig_q | ~ANOK;

    gpio_pad_ctl #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_pad (
        .dir_i(dir_q), .lat_i(lat_q), .od_i(od_q), .pu_i(pu_q),
        .dig_eff_i(dig_eff), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pad_in), .pin_sync(pin_sync)
    );

    // Digital pin view: unimplemented and analog-mode pins read as zero.
    always_comb pin_view = pin_sync & IMPL & dig_eff;

    // Read multiplexer keyed by the register select.
    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_DIR: bus_rdata = dir_q;
            SEL_PIN: bus_rdata = pin_view;
            SEL_LAT: bus_rdata = lat_q;
            SEL_OD:  bus_rdata = od_q;
            SEL_PU:  bus_rdata = pu_q;
            SEL_DIG: bus_rdata = dig_q;
            default: bus_rdata = '0;
        endcase
    end

    // R2
    oe_only_on_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);

    // R5
    od_drives_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & od_q & lat_q) == '0) && ((pad_out & od_q) == '0));

    // R7
    pullup_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ~(PULL_MASK[WIDTH-1:0] & IMPL)) == '0);

    // R8
    analog_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe | pin_view) & ANOK & ~dig_q) == '0));

    // R9
    unimpl_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out | bus_rdata) & ~IMPL) == '0);
endmodule

// File: tb/gpio_port16_tb_top.sv
// Scoreboard bench for gpio_port16. Driver tasks queue the expected
// observations, and a monitor at the falling edge pops and compares them.
module gpio_port16_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wen = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, pad_in, pad_out, pad_oe, pad_pu;
    logic [15:0] ext_en = '0, ext_val = '0, force_low = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Scoreboard queues: kind 0 rdata, 1 pad_oe, 2 pad_out, 3 pad_pu.
    int          q_kind[$];
    logic [15:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    // Pad model: external force low wins, then the driver, then an
    // external source, then the pullup. A floating pin reads 0.
    always_comb begin
        for (int i = 0; i < 16; i++) begin
            if (force_low[i])   pad_in[i] = 1'b0;
            else if (pad_oe[i]) pad_in[i] = pad_out[i];
            else if (ext_en[i]) pad_in[i] = ext_val[i];
            else                pad_in[i] = pad_pu[i];
        end
    end

    gpio_port16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // Monitor: pops one expected item per falling edge and compares it.
    always @(negedge clk) begin
        if (q_kind.size() > 0) begin
            int          k;
            logic [15:0] e, a;
            string       t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            case (k)
                0: a = bus_rdata;
                1: a = pad_oe;
                2: a = pad_out;
                default: a = pad_pu;
            endcase
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_wen = 1'b0;
    endtask

    // Queue an expectation for the falling edge after the next rising edge.
    task automatic expect_at(input logic [2:0] a, input int kind,
                             input logic [15:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        q_kind.push_back(kind); q_exp.push_back(e); q_tag.push_back(t);
        @(negedge clk); #0.5;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
        expect_at(a, 0, e, t);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] snap;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 16'h3FFF, "R1 dir");
        rd(3'd2, 16'h0000, "R1 latch");
        rd(3'd3, 16'h0000, "R1 od");
        rd(3'd4, 16'h0000, "R1 pu");
        rd(3'd5, 16'h0000, "R1 dig");
        expect_at(3'd0, 1, 16'h0000, "R1 oe");
        // R3 both addresses load latch, R9 masking
        wr(3'd2, 16'hA5A5);
        rd(3'd2, 16'h25A5, "R3 latch addr R9 mask");
        wr(3'd1, 16'h1234);
        rd(3'd2, 16'h1234, "R3 pin addr");
        // R2 direction
        wr(3'd0, 16'hFF00);
        expect_at(3'd0, 1, 16'h00FF, "R2 oe");
        expect_at(3'd0, 2, 16'h1234, "R2 out");
        idle(2);
        rd(3'd1, 16'h0034, "R4 pin read");
        // R4 latency: change pads right after an edge
        @(posedge clk); #1;
        ext_en = 16'hF000; ext_val = 16'hF000;
        rd(3'd1, 16'h0034, "R4 one edge");
        rd(3'd1, 16'h3034, "R4 two edges R9");
        // R8 analog gating of inputs
        ext_en = 16'hFF00; ext_val = 16'hFF00;
        idle(3);
        rd(3'd1, 16'h3034, "R8 analog reads 0");
        wr(3'd5, 16'hFFFF);
        rd(3'd5, 16'h0F00, "R8 dig mask");
        idle(2);
        rd(3'd1, 16'h3F34, "R8 digital read");
        // R8 analog output disable
        ext_en = '0;
        wr(3'd5, 16'h0000);
        wr(3'd0, 16'h0000);
        expect_at(3'd0, 1, 16'h30FF, "R8 oe off");
        wr(3'd5, 16'h0F00);
        expect_at(3'd0, 1, 16'h3FFF, "R2 all out");
        // R5/R6 open drain with held-low pin
        wr(3'd2, 16'h00F0);
        wr(3'd3, 16'h00FF);
        expect_at(3'd0, 1, 16'h3F0F, "R5 oe");
        expect_at(3'd0, 2, 16'h0000, "R5 out");
        force_low = 16'h0010;
        wr(3'd4, 16'hFFFF);
        rd(3'd4, 16'h00FF, "R7 pu reg");
        expect_at(3'd0, 3, 16'h00FF, "R7 pad_pu");
        idle(2);
        rd(3'd1, 16'h00E0, "R6 pin held low");
        rd(3'd2, 16'h00F0, "R6 latch");
        // R10 read-modify-write through pin address
        @(posedge clk); #1;
        bus_addr = 3'd1;
        #0.5 snap = bus_rdata;
        wr(3'd1, snap | 16'h0001);
        rd(3'd2, 16'h00E1, "R10 bit4 lost");
        // R9/R7 ignored writes
        wr(3'd3, 16'hC000);
        rd(3'd3, 16'h0000, "R9 od write ignored");
        wr(3'd4, 16'hFF00);
        rd(3'd4, 16'h0000, "R7 pu unsupported");
        expect_at(3'd0, 3, 16'h0000, "R7 pad_pu off");
        // R11 reserved addresses
        wr(3'd6, 16'hFFFF);
        rd(3'd6, 16'h0000, "R11 rsv read");
        rd(3'd0, 16'h0000, "R11 dir unchanged");
        rd(3'd2, 16'h00E1, "R11 latch unchanged");
        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule